// File: doc/BRIEF.md
# Selectable-PC Register File Unit

This block holds sixteen 16-bit general registers and three 4-bit selectors that give those registers their roles. The program-counter selector picks the register through which the next instruction byte is fetched. The index selector picks the register that addresses data memory in the execute cycle. The operand selector is loaded with the low nibble of each instruction byte. No register is permanently the program counter. Software changes the flow of control by loading a new value into the program-counter selector.

The unit alternates between a boundary cycle and an execute cycle. A boundary cycle does one of three things:
- serves a DMA transfer through register 0, which then increments;
- takes an interrupt;
- fetches an instruction byte through the program-counter register, which then increments.

A DMA request has priority in the boundary cycle. An interrupt is taken only when the enable flag is set.

On interrupt entry both selectors are packed into an 8-bit save register, and the selectors are forced to registers 1 and 2. A return command unpacks them again. In the execute cycle, which follows each fetch, an external decoder issues one command per instruction. The operand and index registers are exposed to the accumulator path, and a separate port reads any of the thirty-two byte halves.

Top module: `selpc_regfile_unit`

## Requirements
- R1: After a synchronous active-low reset, all registers, P, X, N, T and the opcode read 0, the interrupt-enable flag reads 1, and the unit is at a boundary (exec_cycle = 0).
- R2: At a boundary with dma_req low and no interrupt taken, fetch_en is 1 and mem_addr equals R(P). At the next edge, opcode takes mem_rdata[7:4], N takes mem_rdata[3:0], and R(P) increments modulo 2^16.
- R3: At a boundary with dma_req high, dma_ack is 1, mem_addr equals R0, R0 increments modulo 2^16, and neither a fetch nor an interrupt happens in that cycle.
- R4: At a boundary with dma_req low, irq high and the enable flag 1, int_ack is 1. At the next edge T becomes {X,P} (X in bits 7:4, P in bits 3:0), P becomes 1, X becomes 2 and the enable flag clears. No register changes.
- R5: While the enable flag is 0, irq has no effect and the boundary performs a fetch.
- R6: ex_cmd 7 (return) in an execute cycle loads P from T[3:0] and X from T[7:4], and sets the enable flag.
- R7: ex_cmd 5 loads P from N, and ex_cmd 6 loads X from N, both in an execute cycle.
- R8: ex_cmd 1 increments R(N) and ex_cmd 2 decrements R(N), both modulo 2^16.
- R9: ex_cmd 3 writes ex_byte into bits 7:0 of R(N), and ex_cmd 4 writes it into bits 15:8. The other half is kept.
- R10: half_data is combinationally the byte of R(half_sel[4:1]) selected by half_sel[0] (1 = bits 15:8).
- R11: n_word is R(N) and x_word is R(X). In an execute cycle mem_addr is R(X).
- R12: Each fetch is followed by exactly one execute cycle. In it, dma_req and irq have no effect, and ex_cmd 0 changes nothing. ex_cmd is ignored outside execute cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dma_req | input | 1 | DMA transfer request |
| irq | input | 1 | Interrupt request |
| mem_rdata | input | 8 | Instruction byte read at mem_addr |
| ex_cmd | input | 3 | Execute-cycle command from the decoder |
| ex_byte | input | 8 | Byte from the accumulator path for byte writes |
| half_sel | input | 5 | Byte-half read index |
| mem_addr | output | 16 | Memory address for the current cycle |
| fetch_en | output | 1 | Instruction fetch in this cycle |
| dma_ack | output | 1 | DMA transfer in this cycle |
| int_ack | output | 1 | Interrupt entry in this cycle |
| exec_cycle | output | 1 | Execute cycle in progress |
| opcode | output | 4 | Upper nibble of the last instruction |
| n_sel | output | 4 | Operand selector N |
| p_sel | output | 4 | Program-counter selector P |
| x_sel | output | 4 | Index selector X |
| t_reg | output | 8 | Saved {X,P} |
| ie_flag | output | 1 | Interrupt-enable flag |
| n_word | output | 16 | R(N) |
| x_word | output | 16 | R(X) |
| half_data | output | 8 | Selected byte half |

## Verification
The bench targets these corner cases:
- A program counter at 0xFFFF must wrap to 0. A wrong carry width would leave it stuck or spill the carry into the wrong place.
- A DMA request that arrives together with an interrupt must win, and one that arrives during an execute cycle must wait. A wrong priority order would fetch while DMA is pending, or take the interrupt first.
- Interrupt entry followed by return must restore both selectors. A design that swapped the nibbles of T would resume through the wrong program counter.
- Byte writes and byte reads must land on the named half. A mix-up would corrupt the other half.
- A random stream of requests and commands is compared on every clock against a behavioural model.

// File: rtl/selpc_pkg.sv
// Package: shared command and action encodings for the selectable-PC register file.
// Assumes one action per clock; the command encoding is fixed by the decoder.
package selpc_pkg;
    typedef enum logic [2:0] {
        CMD_NOP    = 3'd0,
        CMD_INC_N  = 3'd1,
        CMD_DEC_N  = 3'd2,
        CMD_PUT_LO = 3'd3,
        CMD_PUT_HI = 3'd4,
        CMD_SEL_P  = 3'd5,
        CMD_SEL_X  = 3'd6,
        CMD_RETURN = 3'd7
    } exec_cmd_e;

    typedef enum logic [1:0] {
        ACT_EXEC  = 2'd0,
        ACT_DMA   = 2'd1,
        ACT_INT   = 2'd2,
        ACT_FETCH = 2'd3
    } action_e;
endpackage

// File: rtl/selpc_regbank.sv
// Module: register bank of NREG words with one byte-enabled write port,
// three word read ports and one byte-half read port.
// Assumes WORD_W is even; half index bit 0 picks the upper half when 1.
module selpc_regbank #(
    parameter int NREG   = 16,
    parameter int WORD_W = 16,
    parameter int SEL_W  = $clog2(NREG),
    parameter int HALF_W = WORD_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [1:0]        wr_be,
    input  logic [SEL_W-1:0]  a_idx,
    output logic [WORD_W-1:0] a_data,
    input  logic [SEL_W-1:0]  n_idx,
    output logic [WORD_W-1:0] n_data,
    input  logic [SEL_W-1:0]  x_idx,
    output logic [WORD_W-1:0] x_data,
    input  logic [SEL_W:0]    h_idx,
    output logic [HALF_W-1:0] h_data
);
    logic [NREG-1:0][WORD_W-1:0] bank;
    logic [WORD_W-1:0]           h_word;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [HALF_W-1:0] lo_q, hi_q;
        logic              hit;
        assign hit = wr_en && (wr_idx == SEL_W'(g));

        // Holds one register; each half is written under its own enable.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q <= '0;
                hi_q <= '0;
            end else if (hit) begin
                if (wr_be[0]) lo_q <= wr_data[HALF_W-1:0];
                if (wr_be[1]) hi_q <= wr_data[WORD_W-1:HALF_W];
            end
        end
        assign bank[g] = {hi_q, lo_q};
    end

    assign a_data = bank[a_idx];
    assign n_data = bank[n_idx];
    assign x_data = bank[x_idx];
    assign h_word = bank[h_idx[SEL_W:1]];
    assign h_data = h_idx[0] ? h_word[WORD_W-1:HALF_W] : h_word[HALF_W-1:0];
endmodule

// File: rtl/selpc_sequencer.sv
// Module: picks the action for each cycle (DMA, interrupt, fetch, execute).
// Assumes an execute cycle always follows a fetch and lasts one clock;
// DMA outranks interrupts, which are taken only at a boundary.
module selpc_sequencer (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dma_req,
    input  logic                irq,
    input  logic                ie,
    output selpc_pkg::action_e  act,
    output logic                in_exec
);
    import selpc_pkg::*;

    // Priority choice of the current action.
    always_comb begin
        if (in_exec)          act = ACT_EXEC;
        else if (dma_req)     act = ACT_DMA;
        else if (irq && ie)   act = ACT_INT;
        else                  act = ACT_FETCH;
    end

    // Enters the execute cycle after each fetch and leaves it after one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) in_exec <= 1'b0;
        else        in_exec <= (act == ACT_FETCH);
    end
endmodule

// File: rtl/selpc_selectors.sv
// Module: the P, X and N selectors, the save register T, the interrupt
// enable flag and the opcode latch. Assumes T packs X above P.
module selpc_selectors #(
    parameter int SEL_W      = 4,
    parameter int INSTR_W    = 8,
    parameter int INT_PC_REG = 1,
    parameter int INT_X_REG  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  selpc_pkg::action_e         act,
    input  selpc_pkg::exec_cmd_e       cmd,
    input  logic [INSTR_W-1:0]         instr,
    output logic [SEL_W-1:0]           p,
    output logic [SEL_W-1:0]           x,
    output logic [SEL_W-1:0]           n,
    output logic [2*SEL_W-1:0]         t,
    output logic                       ie,
    output logic [INSTR_W-SEL_W-1:0]   op
);
    import selpc_pkg::*;

    // Updates selectors on fetch, interrupt entry and execute commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p  <= '0;
            x  <= '0;
            n  <= '0;
            t  <= '0;
            ie <= 1'b1;
            op <= '0;
        end else begin
            case (act)
                ACT_FETCH: begin
                    n  <= instr[SEL_W-1:0];
                    op <= instr[INSTR_W-1:SEL_W];
                end
                ACT_INT: begin
                    t  <= {x, p};
                    p  <= SEL_W'(INT_PC_REG);
                    x  <= SEL_W'(INT_X_REG);
                    ie <= 1'b0;
                end
                ACT_EXEC: begin
                    case (cmd)
                        CMD_SEL_P: p <= n;
                        CMD_SEL_X: x <= n;
                        CMD_RETURN: begin
                            p  <= t[SEL_W-1:0];
                            x  <= t[2*SEL_W-1:SEL_W];
                            ie <= 1'b1;
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/selpc_regfile_unit.sv
// Module: top of the selectable-PC register file. Routes the address and
// write path for the action the sequencer picks. Assumes memory returns the
// instruction byte combinationally in the fetch cycle.
module selpc_regfile_unit #(
    parameter int NREG       = 16,
    parameter int WORD_W     = 16,
    parameter int INSTR_W    = 8,
    parameter int DMA_REG    = 0,
    parameter int INT_PC_REG = 1,
    parameter int INT_X_REG  = 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  dma_req,
    input  logic                                  irq,
    input  logic [INSTR_W-1:0]                    mem_rdata,
    input  logic [2:0]                            ex_cmd,
    input  logic [WORD_W/2-1:0]                   ex_byte,
    input  logic [$clog2(NREG):0]                 half_sel,
    output logic [WORD_W-1:0]                     mem_addr,
    output logic                                  fetch_en,
    output logic                                  dma_ack,
    output logic                                  int_ack,
    output logic                                  exec_cycle,
    output logic [INSTR_W-$clog2(NREG)-1:0]       opcode,
    output logic [$clog2(NREG)-1:0]               n_sel,
    output logic [$clog2(NREG)-1:0]               p_sel,
    output logic [$clog2(NREG)-1:0]               x_sel,
    output logic [2*$clog2(NREG)-1:0]             t_reg,
    output logic                                  ie_flag,
    output logic [WORD_W-1:0]                     n_word,
    output logic [WORD_W-1:0]                     x_word,
    output logic [WORD_W/2-1:0]                   half_data
);
    import selpc_pkg::*;

    localparam int SEL_W  = $clog2(NREG);
    localparam int HALF_W = WORD_W / 2;

    action_e           act;
    exec_cmd_e         cmd;
    logic [SEL_W-1:0]  a_idx;
    logic [WORD_W-1:0] a_data;
    logic              wr_en;
    logic [SEL_W-1:0]  wr_idx;
    logic [WORD_W-1:0] wr_data;
    logic [1:0]        wr_be;

    assign cmd = exec_cmd_e'(ex_cmd);

    selpc_sequencer u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .dma_req (dma_req),
        .irq     (irq),
        .ie      (ie_flag),
        .act     (act),
        .in_exec (exec_cycle)
    );

    selpc_selectors #(
        .SEL_W      (SEL_W),
        .INSTR_W    (INSTR_W),
        .INT_PC_REG (INT_PC_REG),
        .INT_X_REG  (INT_X_REG)
    ) u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (act),
        .cmd   (cmd),
        .instr (mem_rdata),
        .p     (p_sel),
        .x     (x_sel),
        .n     (n_sel),
        .t     (t_reg),
        .ie    (ie_flag),
        .op    (opcode)
    );

    selpc_regbank #(
        .NREG   (NREG),
        .WORD_W (WORD_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .wr_be   (wr_be),
        .a_idx   (a_idx),
        .a_data  (a_data),
        .n_idx   (n_sel),
        .n_data  (n_word),
        .x_idx   (x_sel),
        .x_data  (x_word),
        .h_idx   (half_sel),
        .h_data  (half_data)
    );

    // Address register for the boundary cycle: R0 for DMA, otherwise R(P).
    assign a_idx    = (act == ACT_DMA) ? SEL_W'(DMA_REG) : p_sel;
    assign mem_addr = exec_cycle ? x_word : a_data;
    assign fetch_en = (act == ACT_FETCH);
    assign dma_ack  = (act == ACT_DMA);
    assign int_ack  = (act == ACT_INT);

    // Write-port mux: pointer increments at a boundary, operand updates in execute.
    always_comb begin
        wr_en   = 1'b0;
        wr_idx  = n_sel;
        wr_data = a_data + WORD_W'(1);
        wr_be   = 2'b11;
        case (act)
            ACT_DMA: begin
                wr_en  = 1'b1;
                wr_idx = SEL_W'(DMA_REG);
            end
            ACT_FETCH: begin
                wr_en  = 1'b1;
                wr_idx = p_sel;
            end
            ACT_EXEC: begin
                case (cmd)
                    CMD_INC_N: begin
                        wr_en   = 1'b1;
                        wr_data = n_word + WORD_W'(1);
                    end
                    CMD_DEC_N: begin
                        wr_en   = 1'b1;
                        wr_data = n_word - WORD_W'(1);
                    end
                    CMD_PUT_LO: begin
                        wr_en   = 1'b1;
                        wr_data = {ex_byte, ex_byte};
                        wr_be   = 2'b01;
                    end
                    CMD_PUT_HI: begin
                        wr_en   = 1'b1;
                        wr_data = {ex_byte, ex_byte};
                        wr_be   = 2'b10;
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

    localparam int HALF_CHECK = HALF_W;
endmodule

// File: rtl/selpc_checker.sv
// Module: assertion checker bound to the register-file top. Watches the
// top's ports only; assumes synchronous active-low reset.
module selpc_checker #(
    parameter int SEL_W      = 4,
    parameter int INSTR_W    = 8,
    parameter int INT_PC_REG = 1,
    parameter int INT_X_REG  = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                dma_req,
    input logic [INSTR_W-1:0]  mem_rdata,
    input logic [2:0]          ex_cmd,
    input logic                fetch_en,
    input logic                dma_ack,
    input logic                int_ack,
    input logic                exec_cycle,
    input logic [SEL_W-1:0]    n_sel,
    input logic [SEL_W-1:0]    p_sel,
    input logic [SEL_W-1:0]    x_sel,
    input logic [2*SEL_W-1:0]  t_reg,
    input logic                ie_flag
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (p_sel == '0 && x_sel == '0 && t_reg == '0 && ie_flag));

    assert_fetch_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_en |=> (n_sel == $past(mem_rdata[SEL_W-1:0])));

    assert_dma_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!exec_cycle && dma_req) |-> (dma_ack && !fetch_en && !int_ack));

    assert_int_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |=> (p_sel == SEL_W'(INT_PC_REG) && x_sel == SEL_W'(INT_X_REG)
                     && t_reg == {$past(x_sel), $past(p_sel)} && !ie_flag));

    assert_int_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |-> ie_flag);

    assert_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_cycle && ex_cmd == 3'd7) |=>
            (p_sel == $past(t_reg[SEL_W-1:0]) && x_sel == $past(t_reg[2*SEL_W-1:SEL_W]) && ie_flag));

    assert_fetch_then_exec_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_en |=> exec_cycle);

    assert_exec_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        exec_cycle |=> !exec_cycle);

    assert_one_action_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dma_ack, int_ack, fetch_en, exec_cycle}));
endmodule

bind selpc_regfile_unit selpc_checker #(
    .SEL_W      ($clog2(NREG)),
    .INSTR_W    (INSTR_W),
    .INT_PC_REG (INT_PC_REG),
    .INT_X_REG  (INT_X_REG)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dma_req    (dma_req),
    .mem_rdata  (mem_rdata),
    .ex_cmd     (ex_cmd),
    .fetch_en   (fetch_en),
    .dma_ack    (dma_ack),
    .int_ack    (int_ack),
    .exec_cycle (exec_cycle),
    .n_sel      (n_sel),
    .p_sel      (p_sel),
    .x_sel      (x_sel),
    .t_reg      (t_reg),
    .ie_flag    (ie_flag)
);

// File: tb/tb_selpc_regfile_unit.sv
// Bench: behavioural reference model stepped once per clock and compared
// with every output of the unit. Inputs change on the falling edge.
module tb_selpc_regfile_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dma_req = 1'b0, irq = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic [2:0]  ex_cmd = '0;
    logic [7:0]  ex_byte = '0;
    logic [4:0]  half_sel = '0;
    logic [15:0] mem_addr, n_word, x_word;
    logic        fetch_en, dma_ack, int_ack, exec_cycle, ie_flag;
    logic [3:0]  opcode, n_sel, p_sel, x_sel;
    logic [7:0]  t_reg, half_data;

    int checks = 0, failures = 0, cycles = 0;
    bit done = 1'b0;

    // Reference state.
    logic [15:0] mr [16];
    logic [3:0]  mp, mx, mn, mop;
    logic [7:0]  mt;
    bit          mie, mex;

    selpc_regfile_unit dut (
        .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .irq(irq),
        .mem_rdata(mem_rdata), .ex_cmd(ex_cmd), .ex_byte(ex_byte),
        .half_sel(half_sel), .mem_addr(mem_addr), .fetch_en(fetch_en),
        .dma_ack(dma_ack), .int_ack(int_ack), .exec_cycle(exec_cycle),
        .opcode(opcode), .n_sel(n_sel), .p_sel(p_sel), .x_sel(x_sel),
        .t_reg(t_reg), .ie_flag(ie_flag), .n_word(n_word), .x_word(x_word),
        .half_data(half_data)
    );

    always #5 clk = ~clk;

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                       input string req, input string what, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s (%s): actual=%h expected=%h", req, what, tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) mr[i] = '0;
        mp = '0; mx = '0; mn = '0; mop = '0; mt = '0; mie = 1'b1; mex = 1'b0;
    endtask

    // One clock: drive, compare combinational view, advance model, wait.
    task automatic step(input bit dr, input bit ir, input logic [7:0] rd,
                        input logic [2:0] cmd, input logic [7:0] eb,
                        input logic [4:0] hs, input string tag);
        bit e_dma, e_int, e_fetch;
        logic [15:0] e_addr, hw;
        dma_req = dr; irq = ir; mem_rdata = rd; ex_cmd = cmd; ex_byte = eb; half_sel = hs;
        #1;
        e_dma   = !mex && dr;
        e_int   = !mex && !dr && ir && mie;
        e_fetch = !mex && !dr && !(ir && mie);
        e_addr  = mex ? mr[mx] : (dr ? mr[0] : mr[mp]);
        hw      = mr[hs[4:1]];
        chk(32'(fetch_en), 32'(e_fetch), "R2", "fetch_en", tag);
        chk(32'(dma_ack), 32'(e_dma), "R3", "dma_ack", tag);
        chk(32'(int_ack), 32'(e_int), "R4", "int_ack", tag);
        chk(32'(exec_cycle), 32'(mex), "R12", "exec_cycle", tag);
        chk(32'(mem_addr), 32'(e_addr), "R11", "mem_addr", tag);
        chk(32'(opcode), 32'(mop), "R2", "opcode", tag);
        chk(32'(n_sel), 32'(mn), "R2", "n_sel", tag);
        chk(32'(p_sel), 32'(mp), "R7", "p_sel", tag);
        chk(32'(x_sel), 32'(mx), "R7", "x_sel", tag);
        chk(32'(t_reg), 32'(mt), "R4", "t_reg", tag);
        chk(32'(ie_flag), 32'(mie), "R5", "ie_flag", tag);
        chk(32'(n_word), 32'(mr[mn]), "R8", "n_word", tag);
        chk(32'(x_word), 32'(mr[mx]), "R11", "x_word", tag);
        chk(32'(half_data), 32'(hs[0] ? hw[15:8] : hw[7:0]), "R10", "half_data", tag);
        // Advance the reference by one clock.
        if (!rst_n) model_reset();
        else if (!mex) begin
            if (dr) mr[0] = mr[0] + 16'd1;
            else if (ir && mie) begin
                mt = {mx, mp}; mp = 4'd1; mx = 4'd2; mie = 1'b0;
            end else begin
                mop = rd[7:4]; mn = rd[3:0]; mr[mp] = mr[mp] + 16'd1; mex = 1'b1;
            end
        end else begin
            case (cmd)
                3'd1: mr[mn] = mr[mn] + 16'd1;
                3'd2: mr[mn] = mr[mn] - 16'd1;
                3'd3: mr[mn][7:0] = eb;
                3'd4: mr[mn][15:8] = eb;
                3'd5: mp = mn;
                3'd6: mx = mn;
                3'd7: begin mp = mt[3:0]; mx = mt[7:4]; mie = 1'b1; end
                default: ;
            endcase
            mex = 1'b0;
        end
        @(negedge clk);
    endtask

    // Fetch a byte and execute one command on it.
    task automatic instr(input logic [7:0] b, input logic [2:0] cmd,
                         input logic [7:0] eb, input string tag);
        step(1'b0, 1'b0, b, 3'd0, 8'h00, 5'd0, tag);
        step(1'b0, 1'b0, 8'h00, cmd, eb, 5'd0, tag);
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        step(1'b0, 1'b0, 8'h00, 3'd0, 8'h00, 5'd0, "R1 reset state");
        rst_n = 1'b1;
        // R2 fetch through R0, R9 byte writes into R5, R10 half reads.
        instr(8'hA5, 3'd3, 8'h34, "R9 put low");
        instr(8'h35, 3'd4, 8'h12, "R9 put high");
        instr(8'h05, 3'd0, 8'h00, "R12 nop");
        chk(32'(n_word), 32'h1234, "R9", "R5 after byte writes", "directed");
        step(1'b0, 1'b0, 8'h00, 3'd0, 8'h00, 5'd11, "R10 high half of R5");
        step(1'b0, 1'b0, 8'h00, 3'd0, 8'h00, 5'd10, "R10 low half of R5");
        // R8 decrement wraps to FFFF, then R7 makes it the program counter.
        instr(8'h73, 3'd2, 8'h00, "R8 dec wrap");
        instr(8'h03, 3'd6, 8'h00, "R7 sel x");
        instr(8'h03, 3'd5, 8'h00, "R7 sel p");
        // Fetch through R3 = FFFF: wraps to 0 (R2).
        step(1'b0, 1'b0, 8'h9C, 3'd0, 8'h00, 5'd6, "R2 pc wrap");
        // R12 DMA and irq during execute wait; R3 DMA outranks irq.
        step(1'b1, 1'b1, 8'h00, 3'd1, 8'h00, 5'd0, "R12 requests in exec");
        step(1'b1, 1'b1, 8'h00, 3'd0, 8'h00, 5'd0, "R3 dma over irq");
        step(1'b1, 1'b0, 8'h00, 3'd7, 8'h00, 5'd1, "R3 dma again R12 cmd ignored");
        // R4 interrupt entry, then R5 gated irq fetches.
        step(1'b0, 1'b1, 8'h00, 3'd0, 8'h00, 5'd0, "R4 int entry");
        chk(32'(t_reg), 32'h33, "R4", "T packs X,P", "directed");
        step(1'b0, 1'b1, 8'h41, 3'd0, 8'h00, 5'd0, "R5 irq masked fetch");
        step(1'b0, 1'b1, 8'h00, 3'd7, 8'h00, 5'd0, "R6 return");
        chk(32'(p_sel), 32'h3, "R6", "P restored", "directed");
        // Random stream against the model.
        for (int k = 0; k < 600; k++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[1:0] == 2'b00, r[3:2] == 2'b00, r[11:4], r[14:12],
                 r[22:15], r[27:23], "R12 random stream");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule